// File: doc/BRIEF.md
# Comparator Threshold Offset Calibrator

This block removes the per-entry offset of a noisy threshold comparator by measuring it through the very comparison path used at inference time. For every entry of a threshold memory it reads the trained threshold, offers it to the comparator together with a ramp pixel code that starts at zero and climbs one code per comparison, and watches the one-bit decision. The first ramp code at which the decision differs from the decision at the code just before it is the effective threshold that the comparator realises.

The difference between that flip code and the trained value is the offset. The block subtracts it from the trained value, clamps the result to the pixel range, and writes the corrected value back into the same memory entry, so no separate offset storage is needed. The comparator reports each decision with a response-valid pulse after a latency that may vary. A start pulse launches a pass over every entry, and a one-cycle done pulse closes it. If an entry's decision never changes across the whole ramp, the entry is left alone and a sticky error flag is raised.

Top module: `thr_offset_cal`

## Requirements
- R1: After reset, done, noFlipErr, memRdEn, memWrEn and cmpReq are all 0.
- R2: For each entry the block first reads the threshold with memRdEn (read data valid the following cycle), then issues comparisons with cmpThr equal to the stored value and cmpPix taking the codes 0, 1, 2, ... in order, one code per request.
- R3: At most one comparison is outstanding: a new cmpReq is issued only after cmpRespValid has answered the previous one.
- R4: The flip code is the first ramp code whose decision differs from the decision at the preceding code; the sweep of that entry stops at the flip code.
- R5: On a flip, the value 2*T - F (T the stored threshold, F the flip code), clamped to 0..2^DATA_W-1, is written to the same address with memWrEn.
- R6: If no flip occurs up to the top code, nothing is written for that entry, and noFlipErr goes to 1 and stays 1 until reset.
- R7: Entries are processed once each, in ascending address order from 0 to NUM_THR-1.
- R8: done is a one-cycle pulse in the cycle after the last entry's write, or after its last response when that entry had no flip.
- R9: A start pulse while a pass is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration pass |
| done | output | 1 | One-cycle pass completion pulse |
| noFlipErr | output | 1 | Sticky flag: some entry showed no decision change |
| memRdEn | output | 1 | Threshold memory read strobe |
| memRdAddr | output | ADDR_W | Threshold memory read address |
| memRdData | input | DATA_W | Read data, valid the cycle after memRdEn |
| memWrEn | output | 1 | Threshold memory write strobe |
| memWrAddr | output | ADDR_W | Threshold memory write address |
| memWrData | output | DATA_W | Corrected threshold |
| cmpReq | output | 1 | Comparison request pulse |
| cmpThr | output | DATA_W | Threshold offered to the comparator |
| cmpPix | output | DATA_W | Ramp pixel code offered to the comparator |
| cmpRespValid | input | 1 | Comparison result valid pulse |
| cmpDecision | input | 1 | Comparator decision (1 when threshold exceeds pixel) |

## Verification
The bench targets offsets that push the corrected value past either end of the range, where a design without clamping would wrap to a small or large code. It places entries whose effective threshold sits at or below zero or above the top code, so the decision never changes; a design that wrote anyway or forgot the sticky flag would corrupt memory or hide the fault. Flips at code 1 and at the top code check the ends of the sweep, and varying comparator latency with a restart pulse mid-pass exposes a ramp that advances early or a sequencer that restarts.

// File: rtl/calib_pkg.sv
package calib_pkg;
  // Strobes from the controller to the datapath
  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic ldThr;
    logic incRamp;
    logic ldPrev;
    logic ldFlip;
    logic setErr;
  } ctrlStrobes_t;
endpackage

// File: rtl/calib_dp.sv
module calib_dp
  import calib_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_THR = 11520,
  parameter int ADDR_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              cmpDecision,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] thrReg,
  output logic [DATA_W-1:0] ramp,
  output logic              prevQ,
  output logic              havePrev,
  output logic              rampLast,
  output logic              addrLast,
  output logic [DATA_W-1:0] corrVal,
  output logic              errFlag
);
  localparam int SW = DATA_W + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DATA_W) - 1);

  logic [DATA_W-1:0] flipCode;
  logic signed [SW-1:0] diff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr     <= '0;
      thrReg   <= '0;
      ramp     <= '0;
      prevQ    <= 1'b0;
      havePrev <= 1'b0;
      flipCode <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (strb.clrAddr)      addr <= '0;
      else if (strb.incAddr) addr <= addr + 1'b1;
      if (strb.ldThr) begin
        thrReg   <= memRdData;
        ramp     <= '0;
        havePrev <= 1'b0;
      end else if (strb.incRamp) begin
        ramp <= ramp + 1'b1;
      end
      if (strb.ldPrev) begin
        prevQ    <= cmpDecision;
        havePrev <= 1'b1;
      end
      if (strb.ldFlip) flipCode <= ramp;
      if (strb.setErr) errFlag <= 1'b1;
    end
  end

  assign rampLast = (ramp == {DATA_W{1'b1}});
  assign addrLast = (addr == ADDR_W'(NUM_THR - 1));

  // corrected = T - (F - T) = 2T - F, clamped to the code range
  always_comb begin
    diff = $signed({1'b0, thrReg, 1'b0}) - $signed({2'b00, flipCode});
    if (diff < 0)          corrVal = '0;
    else if (diff > MAXV)  corrVal = '1;
    else                   corrVal = diff[DATA_W-1:0];
  end
endmodule

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         cmpRespValid,
  input  logic         cmpDecision,
  input  logic         prevQ,
  input  logic         havePrev,
  input  logic         rampLast,
  input  logic         addrLast,
  output ctrlStrobes_t strb,
  output logic         memRdEn,
  output logic         memWrEn,
  output logic         cmpReq,
  output logic         done
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_LATCH, S_REQ, S_WAIT, S_WR, S_FIN
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    memRdEn   = 1'b0;
    memWrEn   = 1'b0;
    cmpReq    = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.clrAddr = 1'b1;
        nextState    = S_RD;
      end
      S_RD: begin
        memRdEn   = 1'b1;
        nextState = S_LATCH;
      end
      S_LATCH: begin
        strb.ldThr = 1'b1;
        nextState  = S_REQ;
      end
      S_REQ: begin
        cmpReq    = 1'b1;
        nextState = S_WAIT;
      end
      S_WAIT: if (cmpRespValid) begin
        strb.ldPrev = 1'b1;
        if (havePrev && (cmpDecision != prevQ)) begin
          strb.ldFlip = 1'b1;
          nextState   = S_WR;
        end else if (rampLast) begin
          strb.setErr = 1'b1;
          if (addrLast) nextState = S_FIN;
          else begin
            strb.incAddr = 1'b1;
            nextState    = S_RD;
          end
        end else begin
          strb.incRamp = 1'b1;
          nextState    = S_REQ;
        end
      end
      S_WR: begin
        memWrEn = 1'b1;
        if (addrLast) nextState = S_FIN;
        else begin
          strb.incAddr = 1'b1;
          nextState    = S_RD;
        end
      end
      S_FIN: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/thr_offset_cal.sv
module thr_offset_cal
  import calib_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_THR = 11520,
  localparam int ADDR_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              done,
  output logic              noFlipErr,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              cmpReq,
  output logic [DATA_W-1:0] cmpThr,
  output logic [DATA_W-1:0] cmpPix,
  input  logic              cmpRespValid,
  input  logic              cmpDecision
);
  ctrlStrobes_t      strb;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] thrReg, ramp, corrVal;
  logic              prevQ, havePrev, rampLast, addrLast;

  calib_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cmpRespValid(cmpRespValid), .cmpDecision(cmpDecision),
    .prevQ(prevQ), .havePrev(havePrev), .rampLast(rampLast), .addrLast(addrLast),
    .strb(strb), .memRdEn(memRdEn), .memWrEn(memWrEn), .cmpReq(cmpReq), .done(done)
  );

  calib_dp #(.DATA_W(DATA_W), .NUM_THR(NUM_THR), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memRdData(memRdData),
    .cmpDecision(cmpDecision), .addr(addr), .thrReg(thrReg), .ramp(ramp),
    .prevQ(prevQ), .havePrev(havePrev), .rampLast(rampLast), .addrLast(addrLast),
    .corrVal(corrVal), .errFlag(noFlipErr)
  );

  assign memRdAddr = addr;
  assign memWrAddr = addr;
  assign memWrData = corrVal;
  assign cmpThr    = thrReg;
  assign cmpPix    = ramp;
endmodule

// File: rtl/thr_offset_cal_chk.sv
module thr_offset_cal_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              noFlipErr,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic              cmpReq,
  input logic [DATA_W-1:0] cmpPix,
  input logic              cmpRespValid
);
  logic              pend, seen;
  logic [DATA_W-1:0] lastPix;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= 1'b0;
      seen    <= 1'b0;
      lastPix <= '0;
    end else begin
      if (cmpReq)            pend <= 1'b1;
      else if (cmpRespValid) pend <= 1'b0;
      if (memRdEn)     seen <= 1'b0;
      else if (cmpReq) seen <= 1'b1;
      if (cmpReq) lastPix <= cmpPix;
    end
  end

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpReq |-> !pend);

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpReq && seen) |-> (cmpPix == lastPix + 1'b1));

  // R4
  write_after_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(cmpRespValid));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    noFlipErr |=> noFlipErr);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind thr_offset_cal thr_offset_cal_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .noFlipErr(noFlipErr),
  .memRdEn(memRdEn), .memWrEn(memWrEn), .cmpReq(cmpReq),
  .cmpPix(cmpPix), .cmpRespValid(cmpRespValid)
);

// File: tb/thr_offset_cal_bench.sv
module thr_offset_cal_bench;
  localparam int DW = 8;
  localparam int N  = 6;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic done, noFlipErr, memRdEn, memWrEn, cmpReq;
  logic [AW-1:0] memRdAddr, memWrAddr;
  logic [DW-1:0] memRdData, memWrData, cmpThr, cmpPix;
  logic cmpRespValid = 1'b0;
  logic cmpDecision  = 1'b0;

  always #2 clk = ~clk;

  thr_offset_cal #(.DATA_W(DW), .NUM_THR(N)) u_thr_offset_cal (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .noFlipErr(noFlipErr),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .cmpReq(cmpReq), .cmpThr(cmpThr), .cmpPix(cmpPix),
    .cmpRespValid(cmpRespValid), .cmpDecision(cmpDecision)
  );

  int memArr [N];
  int initArr[N];
  int offArr [N];
  int expFlip[N];
  int expVal [N];
  int errors = 0, checks = 0;
  int curAddr = 0, expAddr = 0, expRamp = 0, wrCnt = 0, doneCnt = 0;
  bit pend = 0, prevWr = 0, prevResp = 0;
  int cntdown = 0;
  bit qPend = 0;
  int lfsr = 5;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // threshold memory model, one cycle read latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= DW'(memArr[memRdAddr]);
    if (memWrEn) memArr[memWrAddr] <= int'(memWrData);
  end

  // comparator model: ideal compare with injected offset, latency 1..3
  always @(posedge clk) begin
    cmpRespValid <= 1'b0;
    if (!rstN) cntdown = 0;
    else if (cntdown > 0) begin
      cntdown--;
      if (cntdown == 0) begin
        cmpRespValid <= 1'b1;
        cmpDecision  <= qPend;
      end
    end else if (cmpReq) begin
      cntdown = 1 + (lfsr % 3);
      lfsr = (lfsr * 37 + 11) % 101;
      qPend = (int'(cmpThr) + offArr[curAddr]) > int'(cmpPix);
    end
  end

  // port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (cmpRespValid) begin
        chk(pend, "R3 response without request", 0, 1);
        pend = 0;
      end
      if (memRdEn) begin
        chk(int'(memRdAddr) == expAddr, "R7 read address", int'(memRdAddr), expAddr);
        curAddr = expAddr;
        expAddr++;
        expRamp = 0;
      end
      if (cmpReq) begin
        chk(!pend, "R3 request while outstanding", 1, 0);
        chk(int'(cmpPix) == expRamp, "R2 ramp code", int'(cmpPix), expRamp);
        chk(int'(cmpThr) == initArr[curAddr], "R2 compared threshold", int'(cmpThr), initArr[curAddr]);
        expRamp++;
        pend = 1;
      end
      if (memWrEn) begin
        chk(expFlip[curAddr] >= 0, "R6 write for entry without flip", 1, 0);
        chk(int'(memWrAddr) == curAddr, "R5 write address", int'(memWrAddr), curAddr);
        chk(int'(memWrData) == expVal[curAddr], "R5 corrected value", int'(memWrData), expVal[curAddr]);
        chk(expRamp == expFlip[curAddr] + 1, "R4 sweep stops at flip", expRamp, expFlip[curAddr] + 1);
        wrCnt++;
      end
      if (done) begin
        chk(prevWr || prevResp, "R8 done timing", 0, 1);
        chk(expAddr == N, "R7 all entries visited", expAddr, N);
        doneCnt++;
      end
    end
    prevWr   = memWrEn;
    prevResp = cmpRespValid;
  end

  task automatic loadSet(input int setId);
    int t[N], o[N];
    case (setId)
      0: begin t = '{100, 37, 200, 5, 250, 128}; o = '{3, -7, 0, 20, -20, 1}; end
      1: begin t = '{3, 250, 1, 255, 60, 12};    o = '{-5, 10, 0, 0, -60, 2}; end
      default: begin t = '{10, 20, 30, 40, 50, 60}; o = '{1, 2, 3, -1, -2, -3}; end
    endcase
    for (int i = 0; i < N; i++) begin
      int teff, c;
      initArr[i] = t[i];
      memArr[i]  = t[i];
      offArr[i]  = o[i];
      teff = t[i] + o[i];
      if (teff <= 0 || teff > 255) begin
        expFlip[i] = -1;
        expVal[i]  = t[i];
      end else begin
        expFlip[i] = teff;
        c = 2 * t[i] - teff;
        expVal[i] = (c < 0) ? 0 : (c > 255) ? 255 : c;
      end
    end
  endtask

  task automatic runPass(input int setId, input bit expErr);
    int expWr = 0;
    int waited = 0;
    loadSet(setId);
    for (int i = 0; i < N; i++) if (expFlip[i] >= 0) expWr++;
    expAddr = 0; wrCnt = 0; doneCnt = 0; pend = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1;                     // R9: restart attempt mid-pass
    @(negedge clk); start = 1'b0;
    while (doneCnt == 0 && waited < 60000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited < 60000, "R8 pass finished (watchdog)", waited, 60000);
    repeat (3) @(negedge clk);
    chk(doneCnt == 1, "R8 R9 single done pulse", doneCnt, 1);
    chk(wrCnt == expWr, "R6 R9 write count", wrCnt, expWr);
    chk(!done, "R8 done dropped", int'(done), 0);
    for (int i = 0; i < N; i++)
      chk(memArr[i] == expVal[i], "R5 R6 stored value", memArr[i], expVal[i]);
    chk(noFlipErr == expErr, "R6 no-flip flag", int'(noFlipErr), int'(expErr));
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin offArr[i] = 0; memArr[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !noFlipErr && !memRdEn && !memWrEn && !cmpReq, "R1 reset outputs",
        int'({done, noFlipErr, memRdEn, memWrEn, cmpReq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    runPass(0, 1'b0);   // clamps both ends
    runPass(1, 1'b1);   // no-flip entries, flips at codes 1 and 255
    runPass(2, 1'b1);   // flag stays sticky
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(!noFlipErr && !done, "R1 R6 flag cleared by reset", int'(noFlipErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    runPass(2, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule